// File: doc/BRIEF.md
# Page-Mode DRAM Controller

This controller sits between a simple request port and an asynchronous DRAM of 256K bytes whose row and column addresses share nine address pins. A request carries an 18-bit byte address, a direction and, for writes, a data byte. It is accepted on a valid/ready handshake. The upper nine address bits select the row and the lower nine bits select the column. The controller drives the four active-low strobes (row strobe, column strobe, write enable and output enable), multiplexes the address pins, and drives the shared 8-bit data bus only while a write strobe is in progress. Read data comes back on `rd_data` with a one-cycle `rd_valid` pulse.

After an access the row stays open, with the row strobe held low. A later request to the same row costs only a column cycle. A request to another row, or a due refresh, closes the row and waits out a precharge time before a new row is opened. A free-running timer asks for a refresh every `REF_INTERVAL` cycles. Each refresh is a row-strobe-only cycle on the next row of an internal 9-bit counter. All timing values are counted in clock cycles.

The state machine has seven states. `ST_IDLE` means no row is open. `ST_ACTIVATE` holds the row strobe low with the row address on the pins. `ST_COL_SETUP` puts the column address on the pins and sets WE/OE, with the column strobe still high. `ST_STROBE` holds the column strobe low. `ST_PAGE` keeps the row open between accesses. `ST_PRECHARGE` holds the row strobe high. `ST_REFRESH` performs the row-only refresh.

The transitions are as follows:
- From `ST_IDLE`: a due refresh goes to `ST_REFRESH`; an accepted request goes to `ST_ACTIVATE`.
- From `ST_ACTIVATE`: after `T_RCD` cycles, go to `ST_COL_SETUP`.
- From `ST_COL_SETUP`: always go to `ST_STROBE`.
- From `ST_STROBE`: after `T_CAS` cycles, go to `ST_PAGE`.
- From `ST_PAGE`: an accepted same-row request goes to `ST_COL_SETUP`; a due refresh or a pending request to another row goes to `ST_PRECHARGE`.
- From `ST_REFRESH`: after `T_REF_RAS` cycles, go to `ST_PRECHARGE`.
- From `ST_PRECHARGE`: after `T_RP` cycles, go to `ST_IDLE`.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: In reset and on its release, all four strobes are high (inactive), `rd_valid` is low and `req_ready` is high.
- R2: A read of an address returns the byte last written to it. The row is address bits 17:9 and the column is bits 8:0.
- R3: A request to the open row produces a column cycle without a new row-strobe fall. With no request pending, the row strobe stays low.
- R4: Between a rise and the next fall of the row strobe, it stays high for at least `T_RP` cycles.
- R5: For a write, WE is low in the cycle before the column strobe falls and OE stays high. For a read, OE is low and WE is high. WE and OE are never low together.
- R6: The column strobe falls only while the row strobe is low, and no earlier than `T_RCD`+1 cycles after the row strobe fell. The pins carry the row when the row strobe falls and the column when the column strobe falls.
- R7: A refresh is a row-strobe cycle with the column strobe held high. Refresh rows step by one from 0. Successive refreshes start `REF_INTERVAL` cycles apart, within the duration of one access plus precharge.
- R8: Each read yields exactly one one-cycle `rd_valid` pulse, and the pulses come in request order.
- R9: `req_ready` is low in the cycle after a request is accepted, while the access is being started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address: row in bits 17:9, column in bits 8:0 |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 8 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_dq | inout | 8 | Shared data bus |

## Verification
The bench targets these corner cases:
- **Page hits after a refresh.** A burst of same-row accesses starts right after a refresh, and the bench counts row openings. A controller that reopened the row for every access would show extra openings, and one that closed the row when idle would show the row strobe high.
- **Row changes.** Row changes are mixed into a pseudo-random stream while a behavioural memory measures precharge time, row-to-column delay and write-enable setup. Shortened timing, a late write enable or a wrong address phase would corrupt the data the scoreboard compares.
- **Refresh under load.** Refreshes arrive during this traffic. A refresh that skipped rows, fired a column strobe or was starved by page hits would break the row sequence or the interval bound.

// File: rtl/fpm_dram_pkg.sv
package fpm_dram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACTIVATE,
        ST_COL_SETUP,
        ST_STROBE,
        ST_PAGE,
        ST_PRECHARGE,
        ST_REFRESH
    } ctrl_state_e;

endpackage

// File: rtl/dram_wait_cnt.sv
module dram_wait_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign done = (remain == '0);

endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int INTERVAL = 3125,
    parameter int ROW_W    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    output logic             pending,
    output logic [ROW_W-1:0] next_row
);

    localparam int TICK_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(INTERVAL - 1);

    logic [TICK_W-1:0] tick;
    logic              wrap;

    assign wrap = (tick == TICK_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick     <= '0;
            pending  <= 1'b0;
            next_row <= '0;
        end else begin
            tick <= wrap ? '0 : tick + 1'b1;
            if (wrap) begin
                pending <= 1'b1;
            end else if (ack) begin
                pending <= 1'b0;
            end
            if (ack) begin
                next_row <= next_row + 1'b1;
            end
        end
    end

    // R7: a refresh is only completed while one is owed
    a_r7_ack_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> pending);

    // R7: an owed refresh is not dropped before it is served
    a_r7_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
        pending && !ack |=> pending);

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
    import fpm_dram_pkg::*;
#(
    parameter int PIN_W        = 9,
    parameter int DATA_W       = 8,
    parameter int T_RCD        = 2,
    parameter int T_CAS        = 2,
    parameter int T_RP         = 3,
    parameter int T_REF_RAS    = 3,
    parameter int REF_INTERVAL = 3125
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [2*PIN_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic                dram_ras_n,
    output logic                dram_cas_n,
    output logic                dram_we_n,
    output logic                dram_oe_n,
    output logic [PIN_W-1:0]    dram_addr,
    inout  wire  [DATA_W-1:0]   dram_dq
);

    localparam int ADDR_W = 2 * PIN_W;
    localparam int T_A    = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int T_B    = (T_RP > T_REF_RAS) ? T_RP : T_REF_RAS;
    localparam int T_MAX  = (T_A > T_B) ? T_A : T_B;
    localparam int CNT_W  = (T_MAX > 1) ? $clog2(T_MAX) : 1;

    ctrl_state_e state, state_nx;

    logic [ADDR_W-1:0] lat_addr;
    logic              lat_write;
    logic [DATA_W-1:0] lat_wdata;
    logic [PIN_W-1:0]  open_row;
    logic [PIN_W-1:0]  req_row;
    logic              req_hit;
    logic              accept;
    logic              wait_load;
    logic [CNT_W-1:0]  wait_val;
    logic              wait_done;
    logic              ref_pending;
    logic              ref_ack;
    logic [PIN_W-1:0]  ref_row;
    logic              dq_drive;

    dram_wait_cnt #(.CNT_W(CNT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wait_load),
        .load_val (wait_val),
        .done     (wait_done)
    );

    dram_refresh_timer #(.INTERVAL(REF_INTERVAL), .ROW_W(PIN_W)) u_refresh (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack      (ref_ack),
        .pending  (ref_pending),
        .next_row (ref_row)
    );

    assign req_row   = req_addr[ADDR_W-1:PIN_W];
    assign req_hit   = (req_row == open_row);
    assign req_ready = !ref_pending &&
                       ((state == ST_IDLE) || ((state == ST_PAGE) && req_hit));
    assign accept    = req_valid && req_ready;
    assign ref_ack   = (state == ST_REFRESH) && wait_done;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ref_pending)    state_nx = ST_REFRESH;
                else if (req_valid) state_nx = ST_ACTIVATE;
            end
            ST_ACTIVATE:  if (wait_done) state_nx = ST_COL_SETUP;
            ST_COL_SETUP: state_nx = ST_STROBE;
            ST_STROBE:    if (wait_done) state_nx = ST_PAGE;
            ST_PAGE: begin
                if (ref_pending)               state_nx = ST_PRECHARGE;
                else if (req_valid && req_hit) state_nx = ST_COL_SETUP;
                else if (req_valid)            state_nx = ST_PRECHARGE;
            end
            ST_PRECHARGE: if (wait_done) state_nx = ST_IDLE;
            ST_REFRESH:   if (wait_done) state_nx = ST_PRECHARGE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        wait_load = (state_nx != state);
        unique case (state_nx)
            ST_ACTIVATE:  wait_val = CNT_W'(T_RCD - 1);
            ST_STROBE:    wait_val = CNT_W'(T_CAS - 1);
            ST_PRECHARGE: wait_val = CNT_W'(T_RP - 1);
            ST_REFRESH:   wait_val = CNT_W'(T_REF_RAS - 1);
            default:      wait_val = '0;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            lat_addr  <= '0;
            lat_write <= 1'b0;
            lat_wdata <= '0;
            open_row  <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                lat_addr  <= req_addr;
                lat_write <= req_write;
                lat_wdata <= req_wdata;
                open_row  <= req_row;
            end
        end
    end

    // read capture at the end of the column strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (state == ST_STROBE) && wait_done && !lat_write;
            if ((state == ST_STROBE) && wait_done && !lat_write) begin
                rd_data <= dram_dq;
            end
        end
    end

    // strobe and address decode
    always_comb begin
        dram_ras_n = 1'b1;
        dram_cas_n = 1'b1;
        dram_we_n  = 1'b1;
        dram_oe_n  = 1'b1;
        dram_addr  = lat_addr[PIN_W-1:0];
        unique case (state)
            ST_ACTIVATE: begin
                dram_ras_n = 1'b0;
                dram_addr  = lat_addr[ADDR_W-1:PIN_W];
            end
            ST_COL_SETUP: begin
                dram_ras_n = 1'b0;
                dram_we_n  = !lat_write;
                dram_oe_n  = lat_write;
            end
            ST_STROBE: begin
                dram_ras_n = 1'b0;
                dram_cas_n = 1'b0;
                dram_we_n  = !lat_write;
                dram_oe_n  = lat_write;
            end
            ST_PAGE:    dram_ras_n = 1'b0;
            ST_REFRESH: begin
                dram_ras_n = 1'b0;
                dram_addr  = ref_row;
            end
            default: ;
        endcase
    end

    assign dq_drive = !dram_we_n;
    assign dram_dq  = dq_drive ? lat_wdata : 'z;

    // R5: write enable settles a cycle before the column strobe falls
    a_r5_we_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) && !dram_we_n |-> $past(!dram_we_n));

    // R5: bus direction strobes never both active
    a_r5_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dram_we_n && !dram_oe_n));

    // R6: column strobe only falls inside an open row
    a_r6_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> $past(!dram_ras_n));

    // R8: read valid is a single-cycle pulse
    a_r8_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R3: a page hit keeps the row strobe low
    a_r3_hit_keeps_ras: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (state == ST_PAGE) |=> !dram_ras_n);

    // R9: ready drops once an access has started
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    generate
        if (T_RP >= 2) begin : g_rp_chk
            // R4: precharge lasts more than a single cycle
            a_r4_precharge_min: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(dram_ras_n) |=> dram_ras_n);
        end
    endgenerate

endmodule

// File: tb/fpm_dram_ctrl_tb.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_tb;

    localparam int T_RCD  = 2;
    localparam int T_CAS  = 2;
    localparam int T_RP   = 3;
    localparam int T_REFR = 3;
    localparam int REF_IV = 400;
    localparam int SLACK  = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        ras_n, cas_n, we_n, oe_n;
    logic [8:0]  dram_addr;
    tri   [7:0]  dram_dq;

    always #2.5 clk = ~clk;

    fpm_dram_ctrl #(
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP),
        .T_REF_RAS(T_REFR), .REF_INTERVAL(REF_IV)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
        .dram_addr(dram_addr), .dram_dq(dram_dq)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dflt(input logic [17:0] a);
        return a[7:0] ^ {a[16:9]} ^ 8'h3C;
    endfunction

    // ---------------- behavioural memory ----------------
    logic [7:0] cells  [int];
    logic [7:0] shadow [int];
    logic [8:0] m_row = '0;
    logic       m_drv = 1'b0;
    logic [7:0] m_q   = '0;
    logic       p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
    bit         cas_seen = 1'b0;
    int         hi_cnt = 1000, lo_cnt = 0;
    int         cyc = 0, fall_cyc = 0, last_ref = -1;
    int         ref_cnt = 0, act_cnt = 0;
    logic [8:0] exp_ref_row = '0;

    assign dram_dq = m_drv ? m_q : 'z;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!we_n && !oe_n) chk(0, "R5 we/oe both low", 0, 1);
            if (!ras_n) begin
                if (p_ras) begin
                    chk(hi_cnt >= T_RP, "R4 precharge", hi_cnt, T_RP);
                    m_row    = dram_addr;
                    cas_seen = 1'b0;
                    fall_cyc = cyc;
                    lo_cnt   = 1;
                end else begin
                    lo_cnt++;
                end
            end else begin
                if (!p_ras) begin
                    hi_cnt = 1;
                    if (!cas_seen) begin
                        // R7 refresh: row-only cycle
                        chk(m_row == exp_ref_row, "R7 refresh row", m_row, exp_ref_row);
                        exp_ref_row = exp_ref_row + 1'b1;
                        if (last_ref >= 0)
                            chk((fall_cyc - last_ref >= REF_IV - SLACK) &&
                                (fall_cyc - last_ref <= REF_IV + SLACK),
                                "R7 refresh interval", fall_cyc - last_ref, REF_IV);
                        last_ref = fall_cyc;
                        ref_cnt++;
                    end
                end else begin
                    hi_cnt++;
                end
            end
            if (!cas_n && p_cas) begin
                chk(!ras_n, "R6 cas under ras", ras_n, 0);
                chk(lo_cnt >= T_RCD + 1, "R6 ras-to-cas", lo_cnt, T_RCD + 1);
                if (!cas_seen) act_cnt++;
                cas_seen = 1'b1;
                if (!we_n) begin
                    chk(!p_we, "R5 we setup", p_we, 0);
                    chk(oe_n, "R5 oe high on write", oe_n, 1);
                    cells[int'({m_row, dram_addr})] = dram_dq;
                end else begin
                    chk(!oe_n, "R5 oe low on read", oe_n, 0);
                end
            end
            if (!cas_n && !oe_n && we_n) begin
                m_q   = cells.exists(int'({m_row, dram_addr})) ?
                        cells[int'({m_row, dram_addr})] : dflt({m_row, dram_addr});
                m_drv = 1'b1;
            end else begin
                m_drv = 1'b0;
            end
        end
        p_ras = ras_n;
        p_cas = cas_n;
        p_we  = we_n;
    end

    // ---------------- scoreboard ----------------
    logic [7:0] expq[$];
    logic       p_rdv = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                if (p_rdv) chk(0, "R8 pulse width", 2, 1);
                if (expq.size() == 0) begin
                    chk(0, "R8 unexpected read", rd_data, 0);
                end else begin
                    logic [7:0] e;
                    e = expq.pop_front();
                    chk(rd_data == e, "R2 read data", rd_data, e);
                end
            end
        end
        p_rdv = rd_valid;
    end

    task automatic issue(input logic wr, input logic [17:0] a, input logic [7:0] d);
        bit acc;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        acc = 1'b0;
        while (!acc) begin
            #1;
            acc = req_ready;
            @(negedge clk);
        end
        #1;
        chk(!req_ready, "R9 ready after accept", req_ready, 0);
        req_valid = 1'b0;
        if (wr) begin
            shadow[int'(a)] = d;
        end else begin
            expq.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : dflt(a));
        end
    endtask

    function automatic logic [17:0] mk(input int row, input int col);
        return {9'(row), 9'(col)};
    endfunction

    task automatic wait_refresh();
        int r0;
        r0 = ref_cnt;
        while (ref_cnt == r0) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        int a0;
        logic [15:0] lf;
        repeat (4) @(negedge clk);
        // R1 reset values
        chk(ras_n && cas_n && we_n && oe_n, "R1 strobes in reset",
            {ras_n, cas_n, we_n, oe_n}, 4'hF);
        chk(!rd_valid, "R1 rd_valid in reset", rd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R1 ready after reset", req_ready, 1);
        chk(ras_n && cas_n, "R1 strobes after reset", {ras_n, cas_n}, 2'b11);

        // R2 basic write then read, plus an unwritten location
        issue(1'b1, mk(5, 3), 8'h5A);
        issue(1'b0, mk(5, 3), 8'h00);
        issue(1'b0, mk(300, 77), 8'h00);

        // R3 page burst right after a refresh
        wait_refresh();
        a0 = act_cnt;
        issue(1'b1, mk(7, 1), 8'hA1);
        issue(1'b1, mk(7, 2), 8'hB2);
        issue(1'b0, mk(7, 1), 8'h00);
        issue(1'b0, mk(7, 2), 8'h00);
        issue(1'b0, mk(7, 10), 8'h00);
        repeat (10) @(negedge clk);
        chk(act_cnt - a0 == 1, "R3 one row opening for burst", act_cnt - a0, 1);
        chk(!ras_n, "R3 row stays open", ras_n, 0);

        // R4 row changes
        a0 = act_cnt;
        issue(1'b1, mk(8, 1), 8'hC3);
        issue(1'b0, mk(7, 2), 8'h00);
        issue(1'b0, mk(8, 1), 8'h00);
        repeat (10) @(negedge clk);
        chk(act_cnt - a0 >= 3, "R4 row change reopens", act_cnt - a0, 3);

        // mixed stream with hits and misses across refreshes
        lf = 16'hACE1;
        for (int i = 0; i < 60; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            issue(lf[6], mk(3 + int'(lf[1:0]), int'(lf[5:2])), lf[15:8]);
        end

        // let several refreshes go by
        while (ref_cnt < 6) @(negedge clk);
        chk(ref_cnt >= 6, "R7 refresh count", ref_cnt, 6);

        repeat (40) @(negedge clk);
        chk(expq.size() == 0, "R8 all reads returned", expq.size(), 0);
        finish_run();
    end

endmodule